// File: doc/BRIEF.md
# Block Erase Sequencer with Suspend

This block controls the internally timed erase of one memory block. A confirm pulse starts the erase and latches the target block address at that moment. The erase then runs in four ordered phases. First every bit of the block is programmed, and a verify checks the result. Then every bit is erased, and a second verify checks that result. Both timed phases last a programmable number of clock cycles. Each verify lasts one cycle and samples a pass input supplied by the surrounding logic, which stands in for the cell checks.

When a verify fails, the phase before it is repeated, up to a programmable retry limit. If the limit is used up, the erase ends with a failure flag. If the supply is out of range when the confirm arrives, no phase runs. The failure flag and a supply-fault flag are set instead.

A suspend request does not stop the sequence at once. It takes effect at the next checkpoint: the end of a timed phase or the end of a verify cycle. The host polls the status byte to see when this has happened. While suspended, the host may read other blocks and may read status. A resume continues from the point where the sequence stopped. A read that targets the suspended block is flagged as an error, and the read path then supplies all-ones data.

Top module: `erase_seq`

## Requirements
- R1: After reset, status_o is 8'h80 (bit 7 ready = 1, bit 6 suspended = 0, bit 5 erase fail = 0, bit 3 supply fault = 0, all other bits 0), and rd_err_o is 0.
- R2: A start while idle with supply_ok_i high clears ready in the next cycle and begins phase_o = 0 (preprogram). The phases then follow in the order 0 (preprogram), 1 (program verify), 2 (erase), 3 (erase verify). Timed phases last prog_len_i and erase_len_i cycles (a length of 0 acts as 1). Each verify lasts 1 cycle. With no verify failures the block is busy for prog_len+1+erase_len+1 cycles, then returns to ready with bit 5 clear.
- R3: A verify that samples verify_ok_i low repeats the phase before it. The retry count resets when a verify passes. The (max_retry_i+1)-th consecutive failure of one verify ends the sequence with ready = 1 and bit 5 set.
- R4: A start while idle with supply_ok_i low runs no phase: ready stays 1, and bits 5 and 3 are set from the next cycle.
- R5: A suspend request during a run keeps ready at 0 until the current timed phase or verify cycle ends. At that point status shows bit 6 = 1 and bit 7 = 1.
- R6: A resume while suspended clears ready in the next cycle and continues with the phase that was due next. The total busy cycles equal those of the same erase run without a suspend.
- R7: While suspended, start and suspend requests are ignored, and blk_o is unchanged. A resume or suspend request while idle is ignored.
- R8: While suspended, rd_err_o is 1 exactly when rd_req_i is high and rd_blk_i equals the latched block. It is 0 for any other block.
- R9: clr_i while idle clears bits 5 and 3.
- R10: A start accepted with a valid supply clears bits 5 and 3 left from an earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Erase confirm pulse |
| blk_i | input | BLK_W | Block address latched on confirm |
| supply_ok_i | input | 1 | Programming supply within limits |
| suspend_i | input | 1 | Suspend request |
| resume_i | input | 1 | Resume request |
| verify_ok_i | input | 1 | Verify result sampled in verify cycles |
| prog_len_i | input | CNT_W | Preprogram phase length in cycles |
| erase_len_i | input | CNT_W | Erase phase length in cycles |
| max_retry_i | input | RTRY_W | Retries allowed per verify |
| clr_i | input | 1 | Clear failure bits while idle |
| rd_req_i | input | 1 | Array read request |
| rd_blk_i | input | BLK_W | Block targeted by the read |
| status_o | output | 8 | Status byte: 7 ready, 6 suspended, 5 erase fail, 3 supply fault |
| phase_o | output | 2 | Current or next phase code |
| blk_o | output | BLK_W | Latched block address |
| rd_err_o | output | 1 | Read targets the suspended block |

## Verification
The assertions assume that the command inputs are single-cycle pulses. They also assume that the length, retry and verify inputs are valid at the cycles where the sequencer samples them. The bench changes configuration only while the block is idle. It drives every request for exactly one clock edge. It sets verify_ok_i at the negative edge before each verify cycle, based on phase_o and a planned count of failures. The suspend assertions also assume that start is never applied during a run, and the bench holds to this.

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int BLK_W  = 3,
  parameter int CNT_W  = 16,
  parameter int RTRY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              supply_ok_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              verify_ok_i,
  input  logic [CNT_W-1:0]  prog_len_i,
  input  logic [CNT_W-1:0]  erase_len_i,
  input  logic [RTRY_W-1:0] max_retry_i,
  input  logic              clr_i,
  input  logic              rd_req_i,
  input  logic [BLK_W-1:0]  rd_blk_i,
  output logic [7:0]        status_o,
  output logic [1:0]        phase_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              rd_err_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SUSP} st_t;
  localparam logic [1:0] PH_PRE = 2'd0;
  localparam logic [1:0] PH_EV  = 2'd3;

  st_t               st;
  logic [1:0]        ph;
  logic [CNT_W-1:0]  cnt;
  logic [RTRY_W-1:0] rty;
  logic              pend, fail_q, vpp_q;
  logic [BLK_W-1:0]  blk_q;

  logic             timed, tdone, boundary, vfail, give_up, finish, want_susp;
  logic [CNT_W-1:0] len;
  logic [1:0]       nxt_ph;

  assign timed     = ~ph[0];
  assign len       = ph[1] ? erase_len_i : prog_len_i;
  assign tdone     = ({1'b0, cnt} + 1'b1) >= {1'b0, len};
  assign boundary  = (st == S_RUN) && (timed ? tdone : 1'b1);
  assign vfail     = !timed && !verify_ok_i;
  assign give_up   = vfail && (rty == max_retry_i);
  assign finish    = (ph == PH_EV) && verify_ok_i;
  assign nxt_ph    = vfail ? ph - 2'd1 : ph + 2'd1;
  assign want_susp = pend | suspend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= PH_PRE;
      cnt    <= '0;
      rty    <= '0;
      pend   <= 1'b0;
      fail_q <= 1'b0;
      vpp_q  <= 1'b0;
      blk_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_i) begin
            blk_q <= blk_i;
            if (supply_ok_i) begin
              st     <= S_RUN;
              ph     <= PH_PRE;
              cnt    <= '0;
              rty    <= '0;
              pend   <= 1'b0;
              fail_q <= 1'b0;
              vpp_q  <= 1'b0;
            end else begin
              fail_q <= 1'b1;
              vpp_q  <= 1'b1;
            end
          end else if (clr_i) begin
            fail_q <= 1'b0;
            vpp_q  <= 1'b0;
          end
        end
        S_RUN: begin
          if (suspend_i) pend <= 1'b1;
          if (!boundary) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (finish) begin
              st   <= S_IDLE;
              pend <= 1'b0;
            end else if (give_up) begin
              st     <= S_IDLE;
              fail_q <= 1'b1;
              pend   <= 1'b0;
            end else begin
              ph <= nxt_ph;
              if (!timed) rty <= vfail ? rty + 1'b1 : '0;
              if (want_susp) begin
                st   <= S_SUSP;
                pend <= 1'b0;
              end
            end
          end
        end
        S_SUSP: if (resume_i) st <= S_RUN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign status_o = {st != S_RUN, st == S_SUSP, fail_q, 1'b0, vpp_q, 3'b000};
  assign phase_o  = ph;
  assign blk_o    = blk_q;
  assign rd_err_o = (st == S_SUSP) && rd_req_i && (rd_blk_i == blk_q);
endmodule

module erase_seq_chk #(
  parameter int BLK_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             supply_ok_i,
  input logic             resume_i,
  input logic             rd_req_i,
  input logic [7:0]       status_o,
  input logic [1:0]       phase_o,
  input logic [BLK_W-1:0] blk_o,
  input logic             rd_err_o
);
  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] && !status_o[6] && start_i && supply_ok_i |=> !status_o[7] && phase_o == 2'd0);
  assert_supply_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] && !status_o[6] && start_i && !supply_ok_i |=> status_o[7] && status_o[5] && status_o[3]);
  assert_susp_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] |-> status_o[7]);
  assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] && resume_i |=> !status_o[7]);
  assert_susp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] && !resume_i |=> status_o[6] && $stable(blk_o));
  assert_rd_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> status_o[6] && rd_req_i);
endmodule

bind erase_seq erase_seq_chk #(.BLK_W(BLK_W)) u_chk (.*);

// File: tb/erase_seq_test.sv
module erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int VP  [NV] = '{3, 2, 4, 1, 5, 6};
  localparam int VE  [NV] = '{4, 5, 2, 3, 1, 2};
  localparam int VM  [NV] = '{2, 3, 1, 2, 0, 0};
  localparam int VPF [NV] = '{0, 1, 2, 0, 0, 0};
  localparam int VEF [NV] = '{0, 2, 0, 3, 0, 1};

  logic clk = 0, rst_n = 0;
  logic start_i = 0, supply_ok_i = 1, suspend_i = 0, resume_i = 0, verify_ok_i = 0;
  logic clr_i = 0, rd_req_i = 0;
  logic [2:0] blk_i = 0, rd_blk_i = 0;
  logic [15:0] prog_len_i = 1, erase_len_i = 1;
  logic [3:0] max_retry_i = 0;
  logic [7:0] status_o;
  logic [1:0] phase_o;
  logic [2:0] blk_o;
  logic rd_err_o;

  int tests = 0, fails = 0, busy_n = 0, pv_seen = 0, ev_seen = 0, pvf_c = 0, evf_c = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_seq uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    start_i = 0; suspend_i = 0; resume_i = 0; clr_i = 0;
    if (!status_o[7]) begin
      busy_n++;
      if (phase_o == 2'd1) begin verify_ok_i = (pv_seen >= pvf_c); pv_seen++; end
      else if (phase_o == 2'd3) begin verify_ok_i = (ev_seen >= evf_c); ev_seen++; end
    end
  endtask

  task automatic arm(input int p, input int e, input int m, input int pf, input int ef);
    prog_len_i = 16'(p); erase_len_i = 16'(e); max_retry_i = 4'(m);
    pvf_c = pf; evf_c = ef; pv_seen = 0; ev_seen = 0; busy_n = 0;
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 5000 && !status_o[7]; g++) tick();
  endtask

  function automatic int exp_busy(input int p, input int e, input int m, input int pf, input int ef, output bit f);
    f = 0;
    if (pf > m) begin f = 1; return (m + 1) * (p + 1); end
    if (ef > m) begin f = 1; return (pf + 1) * (p + 1) + (m + 1) * (e + 1); end
    return (pf + 1) * (p + 1) + (ef + 1) * (e + 1);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ef;
    int eb;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status_o == 8'h80, "R1 status", status_o, 8'h80);
    chk(rd_err_o == 0, "R1 rd_err", rd_err_o, 0);

    for (int i = 0; i < NV; i++) begin
      arm(VP[i], VE[i], VM[i], VPF[i], VEF[i]);
      eb = exp_busy(VP[i], VE[i], VM[i], VPF[i], VEF[i], ef);
      supply_ok_i = 1; blk_i = 3'(i); start_i = 1;
      tick();
      chk(!status_o[7] && phase_o == 2'd0, "R2 start", status_o, 0);
      chk(status_o[5] == 0 && status_o[3] == 0, "R10 bits cleared", status_o, 0);
      wait_ready();
      chk(busy_n == eb, ef ? "R3 busy cycles" : "R2 busy cycles", busy_n, eb);
      chk(status_o[5] == ef && status_o[6] == 0, "R3 fail flag", status_o[5], ef);
      chk(blk_o == 3'(i), "R2 latched block", blk_o, i);
    end

    arm(2, 2, 0, 0, 0);
    supply_ok_i = 0; start_i = 1;
    tick();
    chk(status_o == 8'hA8 && busy_n == 0, "R4 supply fault", status_o, 8'hA8);
    supply_ok_i = 1; clr_i = 1;
    tick();
    chk(status_o == 8'h80, "R9 clear", status_o, 8'h80);

    arm(10, 4, 1, 0, 0);
    blk_i = 3'd5; start_i = 1;
    tick(); tick(); tick();
    suspend_i = 1;
    tick();
    chk(status_o[7] == 0 && status_o[6] == 0, "R5 not yet suspended", status_o, 0);
    for (int g = 0; g < 100 && !status_o[6]; g++) tick();
    chk(busy_n == 10, "R5 suspend at boundary", busy_n, 10);
    chk(status_o == 8'hC0, "R5 suspended status", status_o, 8'hC0);
    rd_req_i = 1; rd_blk_i = 3'd5; #1;
    chk(rd_err_o == 1, "R8 same block", rd_err_o, 1);
    rd_blk_i = 3'd2; #1;
    chk(rd_err_o == 0, "R8 other block", rd_err_o, 0);
    rd_req_i = 0;
    blk_i = 3'd1; start_i = 1;
    tick();
    chk(status_o == 8'hC0 && blk_o == 3'd5, "R7 start ignored", blk_o, 5);
    suspend_i = 1;
    tick(); tick();
    chk(status_o == 8'hC0, "R7 suspend ignored", status_o, 8'hC0);
    resume_i = 1;
    tick();
    chk(!status_o[7] && phase_o == 2'd1, "R6 resume phase", phase_o, 1);
    wait_ready();
    chk(busy_n == 16 && status_o == 8'h80, "R6 total busy", busy_n, 16);

    resume_i = 1;
    tick();
    chk(status_o == 8'h80, "R7 resume idle", status_o, 8'h80);
    suspend_i = 1;
    tick(); tick();
    chk(status_o == 8'h80, "R7 suspend idle", status_o, 8'h80);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule